// File: doc/BRIEF.md
# Embedded Sync Code Timing Decoder

This block sits on a 16-bit 4:2:2 video input that carries one word per pixel clock. Each word holds one luma byte and one chroma byte. Timing reference codes are embedded in the upper byte lane. Each code is a preamble of an all-ones byte and two all-zero bytes, followed by a status byte. The block finds these codes and decodes the field, vertical-blanking and horizontal flags from the status byte. From those flags it rebuilds separate horizontal sync, vertical sync, field and active-enable outputs. The field output lets a downstream capture engine put top and bottom fields in the right order.

The video words come out four cycles late. That delay means a code is fully decoded before its first word reaches the output, so code words are never marked active. The block keeps two counters: active pixels on the current line and active lines in the current field. When checking is enabled it also checks the four protection bits of every status byte. A code that fails the check raises a one-cycle error pulse and its flags are thrown away.

The preamble finder is a four-state machine:
- HUNT: waiting for an all-ones upper byte.
- GOT_FF: one or more all-ones bytes have been seen.
- GOT_Z1: the first zero byte has been seen.
- GOT_Z2: the second zero byte has been seen, and the current word is the status word.

Its transitions:
- HUNT→GOT_FF on an all-ones byte.
- GOT_FF→GOT_FF on a repeated all-ones byte.
- GOT_FF→GOT_Z1 on a zero byte.
- GOT_Z1→GOT_Z2 on a zero byte.
- GOT_Z1→GOT_FF on an all-ones byte.
- GOT_Z2→GOT_FF when the status word is all-ones.
- GOT_Z2→HUNT otherwise.
- Every other byte sends the machine back to HUNT.

Top module: `embedded_sync_decoder`

## Requirements
- R1: A code is recognised only when the upper byte (bits 15:8) carries 0xFF, 0x00, 0x00 on three consecutive words. The fourth word is then the status word. The lower byte lane never affects detection. Extra 0xFF bytes before the zeros still lead to detection.
- R2: The status byte is decoded as F = bit 6, V = bit 5, H = bit 4. H=1 marks end of active video and H=0 marks start of active video. Bit 7 must be 1.
- R3: When chk_en=1, bits 3..0 must equal V^H, F^H, F^V, F^V^H, and bit 7 must be 1. If not, code_err is high for exactly one cycle, aligned with the first output word after the status word, and the code's flags are not applied.
- R4: When chk_en=0, no status byte is checked. code_err stays low and every code's flags are applied.
- R5: hsync_o is high from the output word after a valid end code up to, but not including, the output word after a valid start code.
- R6: vsync_o equals the V flag of the most recent valid code, applied from the output word after that code.
- R7: field_o equals the F flag of the most recent valid end code. Start codes never change it.
- R8: act_en_o is high only for the words between a valid start code with V=0 and the next valid end code. It is never high on a code word.
- R9: vid_out equals vid_in delayed by exactly four clock cycles. All other outputs are aligned to vid_out.
- R10: pix_cnt gives the number of active words output on the current line before the present cycle. It restarts on the word after each valid start code.
- R11: line_cnt gives the number of active lines started in the current field. It restarts on the word after a valid code whose V falls from 1 to 0.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Enables the protection-bit check |
| vid_in | input | 16 | Upper byte: codes and chroma; lower byte: luma |
| vid_out | output | 16 | vid_in delayed four cycles |
| hsync_o | output | 1 | Regenerated horizontal sync |
| vsync_o | output | 1 | Regenerated vertical blanking |
| field_o | output | 1 | Field identity from F |
| act_en_o | output | 1 | Active video enable |
| code_err | output | 1 | One-cycle malformed-code pulse |
| pix_cnt | output | 11 | Active pixels so far on the line |
| line_cnt | output | 10 | Active lines so far in the field |

## Verification
The bench plays interlaced fields of both parities with random pixel words, line widths, blanking lengths and active-line counts. This shows that field_o follows F and does not swap, and that the counters track lines of varying size. Directed patterns cover several cases:
- A code preamble placed only on the lower lane must not be detected.
- A doubled all-ones byte before a code must still be detected.
- A corrupted status byte with checking on must raise the error and leave hsync unchanged.
- The same corruption with checking off must be applied as a normal start code.

Each of these patterns is aimed at a different decode path.

// File: rtl/esd_pkg.sv
package esd_pkg;
    localparam int CODE_LEN = 4;

    typedef enum logic [1:0] {
        HUNT,
        GOT_FF,
        GOT_Z1,
        GOT_Z2
    } det_state_t;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } tflags_t;

    typedef struct packed {
        logic hs;
        logic vs;
        logic fld;
        logic err;
        logic sol;
        logic vfall;
    } ctl_t;
endpackage

// File: rtl/esd_code_fsm.sv
module esd_code_fsm
    import esd_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] lane,
    output logic              hit
);
    det_state_t state_q, state_d;
    logic is_ones, is_zero;

    assign is_ones = (lane == {LANE_W{1'b1}});
    assign is_zero = (lane == {LANE_W{1'b0}});

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = HUNT;
        unique case (state_q)
            HUNT:   state_d = is_ones ? GOT_FF : HUNT;
            GOT_FF: state_d = is_ones ? GOT_FF : (is_zero ? GOT_Z1 : HUNT);
            GOT_Z1: state_d = is_zero ? GOT_Z2 : (is_ones ? GOT_FF : HUNT);
            GOT_Z2: state_d = is_ones ? GOT_FF : HUNT;
        endcase
    end

    always_comb begin
        hit = (state_q == GOT_Z2);
    end

    assert_hit_after_preamble_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(lane, 1) == '0 && $past(lane, 2) == '0 && $past(lane, 3) == '1));
endmodule

// File: rtl/esd_status_check.sv
module esd_status_check
    import esd_pkg::*;
(
    input  logic [7:0] status,
    input  logic       chk_en,
    output tflags_t    flags,
    output logic       bad
);
    logic [3:0] prot_exp;

    always_comb begin
        flags.f  = status[6];
        flags.v  = status[5];
        flags.h  = status[4];
        prot_exp = {flags.v ^ flags.h, flags.f ^ flags.h, flags.f ^ flags.v,
                    flags.f ^ flags.v ^ flags.h};
        bad      = chk_en && (!status[7] || (status[3:0] != prot_exp));
    end
endmodule

// File: rtl/esd_timing.sv
module esd_timing
    import esd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              hit,
    input  tflags_t           flags,
    input  logic              bad,
    output logic [DATA_W-1:0] dout,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              field_o,
    output logic              act_en_o,
    output logic              code_err,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt
);
    localparam int DLY = CODE_LEN;

    logic good, eav, sav;
    ctl_t ctl_q;
    logic inl_q;

    logic [DATA_W-1:0] dat_p [DLY];
    logic [DLY-1:0]    tag_p;
    ctl_t              ctl_p [DLY];
    ctl_t              ctl_o;
    logic              act;
    logic              new_line;

    assign good = hit & ~bad;
    assign eav  = good & flags.h;
    assign sav  = good & ~flags.h;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            inl_q <= 1'b0;
        end else begin
            ctl_q.err   <= hit & bad;
            ctl_q.sol   <= sav;
            ctl_q.vfall <= good & ~flags.v & ctl_q.vs;
            if (good) ctl_q.vs <= flags.v;
            if (eav) begin
                ctl_q.hs  <= 1'b1;
                ctl_q.fld <= flags.f;
                inl_q     <= 1'b0;
            end
            if (sav) begin
                ctl_q.hs <= 1'b0;
                inl_q    <= ~flags.v;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_p[0] <= '0;
            tag_p[0] <= 1'b0;
            ctl_p[0] <= '0;
        end else begin
            dat_p[0] <= din;
            tag_p[0] <= inl_q & ~eav;
            ctl_p[0] <= ctl_q;
        end
    end

    for (genvar k = 1; k < DLY; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dat_p[k] <= '0;
                tag_p[k] <= 1'b0;
                ctl_p[k] <= '0;
            end else begin
                dat_p[k] <= dat_p[k-1];
                tag_p[k] <= tag_p[k-1] & ~eav;
                ctl_p[k] <= ctl_p[k-1];
            end
        end
    end

    assign ctl_o    = ctl_p[DLY-1];
    assign act      = tag_p[DLY-1];
    assign new_line = ctl_o.sol & act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_cnt  <= '0;
            line_cnt <= '0;
        end else begin
            if (ctl_o.sol)  pix_cnt <= {{(PIX_W-1){1'b0}}, act};
            else if (act)   pix_cnt <= pix_cnt + 1'b1;
            if (ctl_o.vfall) line_cnt <= {{(LINE_W-1){1'b0}}, new_line};
            else if (new_line) line_cnt <= line_cnt + 1'b1;
        end
    end

    assign dout     = dat_p[DLY-1];
    assign hsync_o  = ctl_o.hs;
    assign vsync_o  = ctl_o.vs;
    assign field_o  = ctl_o.fld;
    assign code_err = ctl_o.err;
    assign act_en_o = act;

    assert_err_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> !code_err);
    assert_act_outside_hblank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_en_o |-> !hsync_o);
    assert_act_outside_vblank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        act_en_o |-> !vsync_o);
    assert_field_moves_in_hblank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_o) |-> hsync_o);
    assert_pix_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en_o && !ctl_o.sol) |=> (pix_cnt == $past(pix_cnt) + 1'b1));
endmodule

// File: rtl/embedded_sync_decoder.sv
module embedded_sync_decoder
    import esd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_PIX   = 2047,
    parameter int MAX_LINES = 1023,
    localparam int PIX_W    = $clog2(MAX_PIX + 1),
    localparam int LINE_W   = $clog2(MAX_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic [DATA_W-1:0] vid_in,
    output logic [DATA_W-1:0] vid_out,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              field_o,
    output logic              act_en_o,
    output logic              code_err,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt
);
    localparam int LANE_W = DATA_W / 2;

    logic    hit;
    tflags_t flags;
    logic    bad;

    esd_code_fsm #(.LANE_W(LANE_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .lane  (vid_in[DATA_W-1 -: LANE_W]),
        .hit   (hit)
    );

    esd_status_check u_chk (
        .status (vid_in[DATA_W-1 -: 8]),
        .chk_en (chk_en),
        .flags  (flags),
        .bad    (bad)
    );

    esd_timing #(.DATA_W(DATA_W), .PIX_W(PIX_W), .LINE_W(LINE_W)) u_tim (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (vid_in),
        .hit      (hit),
        .flags    (flags),
        .bad      (bad),
        .dout     (vid_out),
        .hsync_o  (hsync_o),
        .vsync_o  (vsync_o),
        .field_o  (field_o),
        .act_en_o (act_en_o),
        .code_err (code_err),
        .pix_cnt  (pix_cnt),
        .line_cnt (line_cnt)
    );
endmodule

// File: tb/embedded_sync_decoder_tb_top.sv
module embedded_sync_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_en = 1'b1;
    logic [15:0] vid_in = '0;
    logic [15:0] vid_out;
    logic        hsync_o, vsync_o, field_o, act_en_o, code_err;
    logic [10:0] pix_cnt;
    logic [9:0]  line_cnt;

    always #10 clk = ~clk;

    embedded_sync_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .vid_in(vid_in),
        .vid_out(vid_out), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .field_o(field_o), .act_en_o(act_en_o), .code_err(code_err),
        .pix_cnt(pix_cnt), .line_cnt(line_cnt)
    );

    localparam int NW = 8192;
    int n_chk = 0, n_bad = 0;
    int wr = 0, cap = 0;
    bit run = 0, done = 0;
    string ctx = "R2";

    logic [15:0] e_data [NW];
    bit e_hs [NW], e_vs [NW], e_fld [NW], e_act [NW], e_err [NW];
    int e_pix [NW], e_line [NW];
    string e_ctx [NW];

    bit m_hs = 0, m_vs = 0, m_fld = 0, m_inl = 0;
    bit p_err = 0, p_sol = 0, p_vfall = 0;
    int bpix = 0, bline = 0;

    function automatic logic [7:0] mk(bit f, bit v, bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic chk(string req, string nm, int a, int e);
        n_chk++;
        if (a != e) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, nm, a, e);
        end
    endtask

    task automatic put_word(logic [15:0] w, bit is_code);
        bit a;
        @(negedge clk);
        vid_in = w;
        run = 1;
        a = is_code ? 1'b0 : m_inl;
        e_data[wr] = w; e_hs[wr] = m_hs; e_vs[wr] = m_vs; e_fld[wr] = m_fld;
        e_act[wr] = a; e_err[wr] = p_err; e_pix[wr] = bpix; e_line[wr] = bline;
        e_ctx[wr] = ctx;
        if (p_sol) bpix = a ? 1 : 0;
        else if (a) bpix++;
        if (p_vfall) bline = (p_sol && a) ? 1 : 0;
        else if (p_sol && a) bline++;
        p_err = 0; p_sol = 0; p_vfall = 0;
        if (wr < NW - 1) wr++;
    endtask

    task automatic put_code(logic [7:0] st);
        bit ok, f, v, h;
        put_word(16'hFF00, 1);
        put_word(16'h0000, 1);
        put_word(16'h0000, 1);
        put_word({st, 8'h00}, 1);
        f = st[6]; v = st[5]; h = st[4];
        ok = st[7] && (st[3:0] == {v ^ h, f ^ h, f ^ v, f ^ v ^ h});
        if (chk_en && !ok) p_err = 1;
        else begin
            p_vfall = !v && m_vs;
            m_vs = v;
            if (h) begin m_hs = 1; m_fld = f; m_inl = 0; end
            else begin m_hs = 0; m_inl = !v; p_sol = 1; end
        end
    endtask

    task automatic send_line(bit f, bit v, int np, int hb);
        put_code(mk(f, v, 1'b1));
        for (int i = 0; i < hb; i++) put_word(16'h8010, 0);
        put_code(mk(f, v, 1'b0));
        for (int i = 0; i < np; i++) begin
            if (v) put_word(16'h8010, 0);
            else put_word({8'(1 + $urandom % 254), 8'($urandom % 256)}, 0);
        end
    endtask

    task automatic send_field(bit f, int np, int nact, int hb);
        for (int i = 0; i < 2; i++) send_line(f, 1'b1, np, hb);
        for (int i = 0; i < nact; i++) send_line(f, 1'b0, np, hb);
        for (int i = 0; i < 2; i++) send_line(f, 1'b1, np, hb);
    endtask

    always @(posedge clk) if (run) cap <= cap + 1;

    always @(negedge clk) begin
        if (run && !done && cap >= 4 && (cap - 4) < wr) begin
            int i;
            i = cap - 4;
            chk({e_ctx[i], "/R9"},  "vid_out",  int'(vid_out),  int'(e_data[i]));
            chk({e_ctx[i], "/R5"},  "hsync",    int'(hsync_o),  int'(e_hs[i]));
            chk({e_ctx[i], "/R6"},  "vsync",    int'(vsync_o),  int'(e_vs[i]));
            chk({e_ctx[i], "/R7"},  "field",    int'(field_o),  int'(e_fld[i]));
            chk({e_ctx[i], "/R8"},  "act_en",   int'(act_en_o), int'(e_act[i]));
            chk({e_ctx[i], "/R3"},  "code_err", int'(code_err), int'(e_err[i]));
            chk({e_ctx[i], "/R10"}, "pix_cnt",  int'(pix_cnt),  e_pix[i]);
            chk({e_ctx[i], "/R11"}, "line_cnt", int'(line_cnt), e_line[i]);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "vid_out",  int'(vid_out), 0);
        chk("R12", "hsync",    int'(hsync_o), 0);
        chk("R12", "vsync",    int'(vsync_o), 0);
        chk("R12", "field",    int'(field_o), 0);
        chk("R12", "act_en",   int'(act_en_o), 0);
        chk("R12", "code_err", int'(code_err), 0);
        chk("R12", "pix_cnt",  int'(pix_cnt), 0);
        chk("R12", "line_cnt", int'(line_cnt), 0);

        for (int i = 0; i < 6; i++) put_word(16'h8010, 0);
        ctx = "R2";
        send_field(1'b0, 16, 4, 8);
        send_field(1'b1, 16, 4, 8);

        ctx = "R1";
        put_code(mk(1'b0, 1'b0, 1'b1));
        put_word(16'h8010, 0);
        put_word(16'hFF10, 0);
        put_code(mk(1'b0, 1'b0, 1'b0));
        put_word(16'h20FF, 0);
        put_word(16'h2000, 0);
        put_word(16'h2000, 0);
        put_word(16'h2080, 0);
        put_word(16'h3344, 0);

        ctx = "R3";
        put_code(mk(1'b0, 1'b0, 1'b1));
        for (int i = 0; i < 3; i++) put_word(16'h8010, 0);
        put_code(mk(1'b0, 1'b0, 1'b0) ^ 8'h01);
        for (int i = 0; i < 3; i++) put_word(16'h8010, 0);
        put_code(8'h00);
        for (int i = 0; i < 3; i++) put_word(16'h8010, 0);
        put_code(mk(1'b0, 1'b0, 1'b0));
        for (int i = 0; i < 5; i++) put_word(16'h4455, 0);

        ctx = "R4";
        chk_en = 1'b0;
        put_code(mk(1'b0, 1'b0, 1'b1));
        for (int i = 0; i < 3; i++) put_word(16'h8010, 0);
        put_code(8'h81);
        for (int i = 0; i < 6; i++) put_word(16'h5566, 0);
        put_code(mk(1'b0, 1'b1, 1'b1));
        chk_en = 1'b1;

        ctx = "R2";
        for (int fi = 0; fi < 6; fi++)
            send_field(fi[0], 6 + $urandom % 15, 2 + $urandom % 4, 2 + $urandom % 7);
        for (int i = 0; i < 8; i++) put_word(16'h8010, 0);
        repeat (6) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule